// File: doc/BRIEF.md
# Data Address Breakpoint Unit

This unit sits beside the load/store path of a processor core and watches every data access. It first relocates the address into the current process's slice when a process-ID field is set and the access falls in the low slice. It then raises an alignment-abort request for a misaligned word access when alignment checking is on. Finally it compares the relocated address against two breakpoint registers and signals a hit to the debug logic.

A control word selects, for each comparator, whether it is off or watches stores, loads or both. One control bit turns the pair into a single masked comparator. In that mode the second register holds an inverted mask over the first address. While global debug is active, breakpoint matching is suppressed. The memory behind the access is outside the block.

Top module: `data_bkpt_unit`

## Requirements
- R1: Each 2-bit filter field selects the access type a comparator watches: 0 = off, 1 = stores only, 2 = any access, 3 = loads only (`acc_store` = 1 marks a store).
- R2: In normal mode (`bp_ctrl[8]` = 0), comparator 0 uses filter `bp_ctrl[1:0]` and `bp_addr0`, and comparator 1 uses filter `bp_ctrl[3:2]` and `bp_addr1`. Each matches when its register equals the relocated address on bits [31:2]; address bits [1:0] are ignored.
- R3: In mask mode (`bp_ctrl[8]` = 1), `bp_addr1` is an inverted mask: a hit needs the relocated address to equal `bp_addr0` on every bit where `bp_addr1` is 0. Only filter `bp_ctrl[1:0]` applies, and field `bp_ctrl[3:2]` has no effect.
- R4: When `pid_reg[31:25]` is nonzero and `acc_addr[31:25]` is zero, the relocated address is `acc_addr` with bits [31:25] replaced by `pid_reg[31:25]`. Otherwise it equals `acc_addr`. It appears on `phys_addr` one cycle after the strobe and holds until the next strobe.
- R5: `align_abort` pulses one cycle after a strobed access when `align_chk_en` = 1 and `acc_addr[1:0]` is nonzero, and stays 0 otherwise.
- R6: While `dbg_global_en` = 1 no breakpoint hit is produced; the alignment check still operates.
- R7: `bp_hit` is a one-cycle pulse one cycle after the strobe. When both comparators match, a single pulse is produced.
- R8: `entry_code` carries 4'h8 in the cycle `bp_hit` is high and 4'h0 otherwise.
- R9: During and right after reset all outputs are zero.
- R10: Breakpoint comparison uses the relocated address, not the raw access address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 32 | Access address |
| acc_store | input | 1 | 1 = store, 0 = load |
| pid_reg | input | 32 | Process-ID register (field in [31:25]) |
| align_chk_en | input | 1 | Alignment checking enable |
| dbg_global_en | input | 1 | Global debug active, suppresses hits |
| bp_ctrl | input | 9 | Filters [1:0], [3:2]; mask mode [8] |
| bp_addr0 | input | 32 | Breakpoint address 0 |
| bp_addr1 | input | 32 | Breakpoint address 1 or inverted mask |
| phys_addr | output | 32 | Registered relocated address |
| align_abort | output | 1 | Alignment abort pulse |
| bp_hit | output | 1 | Data breakpoint hit pulse |
| entry_code | output | 4 | Debug entry code, 8 on hit |

## Verification
The assertions assume that `acc_valid` is a clean level sampled at the rising edge, and that the control, breakpoint and process-ID inputs are stable across the strobe cycle. The bench meets this by changing every input only at falling edges and by holding the configuration steady during each access. It drops the strobe after one cycle, so every pulse can be seen both rising and falling. Configuration changes happen only between accesses, never during one.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  typedef enum logic [1:0] {
    FLT_OFF   = 2'd0,
    FLT_STORE = 2'd1,
    FLT_ANY   = 2'd2,
    FLT_LOAD  = 2'd3
  } acc_filter_e;

  localparam int unsigned MASK_SEL_BIT   = 8;
  localparam int unsigned CTRL_W         = MASK_SEL_BIT + 1;
  localparam int unsigned CODE_W         = 4;
  localparam logic [CODE_W-1:0] ENTRY_DATA_BP = 4'h8;
endpackage

// File: rtl/dbu_pid_reloc.sv
module dbu_pid_reloc #(
  parameter int unsigned AW   = 32,
  parameter int unsigned PIDW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] pid_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned LOW = AW - PIDW;

  logic [PIDW-1:0] pid_f;
  logic [PIDW-1:0] addr_hi;

  always_comb begin
    pid_f   = pid_i[AW-1:LOW];
    addr_hi = addr_i[AW-1:LOW];
    if (pid_f != '0 && addr_hi == '0)
      addr_o = {pid_f, addr_i[LOW-1:0]};
    else
      addr_o = addr_i;
  end
endmodule

// File: rtl/dbu_cmp.sv
module dbu_cmp
  import dbu_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned IGN = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ref_i,
  input  logic [AW-1:0] mask_i,
  input  logic          use_mask_i,
  input  acc_filter_e   filter_i,
  input  logic          is_store_i,
  output logic          hit_o
);
  logic [AW-1:0] care;
  logic          type_ok;

  always_comb begin
    unique case (filter_i)
      FLT_STORE: type_ok = is_store_i;
      FLT_ANY:   type_ok = 1'b1;
      FLT_LOAD:  type_ok = !is_store_i;
      default:   type_ok = 1'b0;
    endcase
    care  = use_mask_i ? ~mask_i : {{(AW-IGN){1'b1}}, {IGN{1'b0}}};
    hit_o = type_ok && (((addr_i ^ ref_i) & care) == '0);
  end

  // R1
  always_comb begin
    off_never_hits_chk: assert (!(filter_i == FLT_OFF && hit_o));
  end
endmodule

// File: rtl/data_bkpt_unit.sv
module data_bkpt_unit
  import dbu_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned PIDW = 7,
  parameter int unsigned NCMP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_store,
  input  logic [AW-1:0]     pid_reg,
  input  logic              align_chk_en,
  input  logic              dbg_global_en,
  input  logic [CTRL_W-1:0] bp_ctrl,
  input  logic [AW-1:0]     bp_addr0,
  input  logic [AW-1:0]     bp_addr1,
  output logic [AW-1:0]     phys_addr,
  output logic              align_abort,
  output logic              bp_hit,
  output logic [CODE_W-1:0] entry_code
);
  localparam int unsigned IGN = 2;

  logic [AW-1:0] reloc;
  logic          mask_mode;
  logic [NCMP-1:0] cmp_hit;
  logic [AW-1:0] ref_a [NCMP];
  acc_filter_e   filt  [NCMP];
  logic          hit_d;
  logic          abort_d;

  assign mask_mode = bp_ctrl[MASK_SEL_BIT];
  assign ref_a[0]  = bp_addr0;
  assign ref_a[1]  = bp_addr1;

  dbu_pid_reloc #(.AW(AW), .PIDW(PIDW)) u_reloc (
    .addr_i(acc_addr),
    .pid_i (pid_reg),
    .addr_o(reloc)
  );

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    if (i == 0) begin : g_first
      assign filt[i] = acc_filter_e'(bp_ctrl[2*i+1:2*i]);
    end else begin : g_other
      assign filt[i] = mask_mode ? FLT_OFF : acc_filter_e'(bp_ctrl[2*i+1:2*i]);
    end
    dbu_cmp #(.AW(AW), .IGN(IGN)) u_cmp (
      .addr_i    (reloc),
      .ref_i     (ref_a[i]),
      .mask_i    (bp_addr1),
      .use_mask_i(mask_mode && (i == 0)),
      .filter_i  (filt[i]),
      .is_store_i(acc_store),
      .hit_o     (cmp_hit[i])
    );
  end

  assign hit_d   = acc_valid && !dbg_global_en && (|cmp_hit);
  assign abort_d = acc_valid && align_chk_en && (|acc_addr[IGN-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr   <= '0;
      align_abort <= 1'b0;
      bp_hit      <= 1'b0;
      entry_code  <= '0;
    end else begin
      align_abort <= abort_d;
      bp_hit      <= hit_d;
      entry_code  <= hit_d ? ENTRY_DATA_BP : '0;
      if (acc_valid) phys_addr <= reloc;
    end
  end

  // R7
  hit_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> $past(acc_valid));

  // R6
  no_hit_in_debug_chk: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> !$past(dbg_global_en));

  // R5
  abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
    align_abort |-> $past(acc_valid && align_chk_en && acc_addr[1:0] != 2'b00));

  // R8
  code_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> entry_code == 4'h8);

  // R8
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bp_hit |-> entry_code == 4'h0);

  // R3
  mask_uses_first_field_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_hit && $past(bp_ctrl[8])) |-> $past(bp_ctrl[1:0] != 2'b00));
endmodule

// File: tb/sim_data_bkpt_unit.sv
`timescale 1ns/1ps
module sim_data_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_store = 1'b0;
  logic [31:0] pid_reg = '0;
  logic        align_chk_en = 1'b0;
  logic        dbg_global_en = 1'b0;
  logic [8:0]  bp_ctrl = '0;
  logic [31:0] bp_addr0 = '0;
  logic [31:0] bp_addr1 = '0;
  logic [31:0] phys_addr;
  logic        align_abort;
  logic        bp_hit;
  logic [3:0]  entry_code;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  data_bkpt_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one strobed access; checks outputs in the result cycle and the cycle after
  task automatic access(input logic [31:0] a, input bit st, input bit exp_hit,
                        input bit exp_abort, input logic [31:0] exp_phys, input string tag);
    @(negedge clk);
    acc_addr = a; acc_store = st; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(bp_hit == exp_hit, {tag, " hit"}, 32'(bp_hit), 32'(exp_hit));
    chk(align_abort == exp_abort, {tag, " abort"}, 32'(align_abort), 32'(exp_abort));
    chk(phys_addr == exp_phys, {tag, " phys"}, phys_addr, exp_phys);
    chk(entry_code == (exp_hit ? 4'h8 : 4'h0), {tag, " R8 code"}, 32'(entry_code), exp_hit ? 32'h8 : 32'h0);
    @(negedge clk);
    chk(bp_hit == 1'b0 && align_abort == 1'b0, {tag, " R7 pulse end"}, {30'b0, bp_hit, align_abort}, 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bp_hit == 0 && align_abort == 0 && entry_code == 0 && phys_addr == 0,
        "R9 reset", {bp_hit, align_abort, entry_code, phys_addr[25:0]}, 32'h0);
  endtask

  task automatic t_filters();
    bp_addr0 = 32'h0000_1000;
    bp_ctrl = 9'h001;
    access(32'h1000, 1, 1, 0, 32'h1000, "R1 store-only store");
    access(32'h1000, 0, 0, 0, 32'h1000, "R1 store-only load");
    bp_ctrl = 9'h003;
    access(32'h1000, 0, 1, 0, 32'h1000, "R1 load-only load");
    access(32'h1000, 1, 0, 0, 32'h1000, "R1 load-only store");
    bp_ctrl = 9'h002;
    access(32'h1000, 0, 1, 0, 32'h1000, "R1 any load");
    access(32'h1000, 1, 1, 0, 32'h1000, "R1 any store");
    bp_ctrl = 9'h000;
    access(32'h1000, 1, 0, 0, 32'h1000, "R1 off");
  endtask

  task automatic t_normal();
    bp_addr0 = 32'h0000_1000; bp_addr1 = 32'h0000_2000;
    bp_ctrl = 9'h002;
    access(32'h1002, 0, 1, 0, 32'h1002, "R2 low bits ignored");
    access(32'h1004, 0, 0, 0, 32'h1004, "R2 next word");
    bp_ctrl = 9'h008;
    access(32'h2003, 1, 1, 0, 32'h2003, "R2 comparator1");
    access(32'h1000, 1, 0, 0, 32'h1000, "R2 comparator0 off");
    bp_ctrl = 9'h004;
    access(32'h2000, 0, 0, 0, 32'h2000, "R2 cmp1 store-only on load");
  endtask

  task automatic t_both();
    bp_addr0 = 32'h3000; bp_addr1 = 32'h3000; bp_ctrl = 9'h00A;
    access(32'h3000, 0, 1, 0, 32'h3000, "R7 both match single pulse");
  endtask

  task automatic t_mask();
    bp_addr0 = 32'h4000; bp_addr1 = 32'h0000_00FF; bp_ctrl = 9'h102;
    access(32'h40AB, 0, 1, 0, 32'h40AB, "R3 masked match");
    access(32'h41AB, 0, 0, 0, 32'h41AB, "R3 unmasked bit differs");
    bp_ctrl = 9'h101;
    access(32'h4012, 0, 0, 0, 32'h4012, "R3 filter on load");
    bp_addr1 = 32'h0000_4000; bp_ctrl = 9'h108;
    access(32'h4000, 0, 0, 0, 32'h4000, "R3 second field ignored");
  endtask

  task automatic t_pid();
    bp_ctrl = 9'h000;
    pid_reg = 32'h0A00_0000;
    access(32'h0000_1000, 0, 0, 0, 32'h0A00_1000, "R4 relocated");
    access(32'h8000_0010, 0, 0, 0, 32'h8000_0010, "R4 high addr kept");
    bp_addr0 = 32'h0A00_1000; bp_ctrl = 9'h002;
    access(32'h0000_1000, 0, 1, 0, 32'h0A00_1000, "R10 compare relocated");
    bp_addr0 = 32'h0000_1000;
    access(32'h0000_1000, 0, 0, 0, 32'h0A00_1000, "R10 raw not compared");
    pid_reg = 32'h0000_0000;
    access(32'h0000_1000, 0, 1, 0, 32'h0000_1000, "R4 zero pid");
  endtask

  task automatic t_align();
    bp_ctrl = 9'h000; align_chk_en = 1'b1;
    access(32'h1001, 0, 0, 1, 32'h1001, "R5 misaligned");
    access(32'h1000, 1, 0, 0, 32'h1000, "R5 aligned");
    align_chk_en = 1'b0;
    access(32'h1003, 0, 0, 0, 32'h1003, "R5 check off");
  endtask

  task automatic t_debug();
    bp_addr0 = 32'h5000; bp_ctrl = 9'h002; dbg_global_en = 1'b1; align_chk_en = 1'b1;
    access(32'h5000, 0, 0, 0, 32'h5000, "R6 hit suppressed");
    access(32'h5002, 0, 0, 1, 32'h5002, "R6 abort still works");
    dbg_global_en = 1'b0; align_chk_en = 1'b0;
    access(32'h5000, 0, 1, 0, 32'h5000, "R6 hit after debug off");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_filters();
    t_normal();
    t_both();
    t_mask();
    t_pid();
    t_align();
    t_debug();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule